// File: doc/BRIEF.md
# Shift Register with Running Ones Tally

This block is a serial-in shift register that always reports how many of its stages hold a one. A new bit enters at the least significant stage on every enabled shift, and the most significant stage is dropped. The count is not recomputed over the whole register. A small up/down counter looks at the two bits that take part in each shift, the bit entering and the bit leaving, and steps by plus one, minus one or zero. The logic depth of the count update therefore does not grow with the length of the register.

A synchronous clear empties the register and zeroes the tally in the same cycle. Clear takes priority over a shift requested in that cycle. While shift enable is low, the register and the tally both keep their values. The parallel contents and the tally are plain registered outputs, so they can be read in any cycle.

Top module: `ones_tally_shreg`

## Requirements
- R1: While the active-low reset `rst_n` is low, `data_q` is all zeros and `ones_q` is zero.
- R2: In a cycle with `shift_en` high and `clear` low, `data_q` becomes its previous value shifted up by one position, with bit 0 taking `din` and the previous bit DEPTH-1 discarded.
- R3: In a cycle with `shift_en` low and `clear` low, `data_q` and `ones_q` keep their values whatever `din` is.
- R4: On a shift where `din` equals the previous bit DEPTH-1 of `data_q`, `ones_q` is unchanged.
- R5: On a shift where `din` is 1 and the previous bit DEPTH-1 is 0, `ones_q` rises by exactly one.
- R6: On a shift where `din` is 0 and the previous bit DEPTH-1 is 1, `ones_q` falls by exactly one.
- R7: When `clear` is high, the next `data_q` is all zeros and the next `ones_q` is zero, even if `shift_en` is high in the same cycle.
- R8: In every cycle after reset, `ones_q` equals the number of ones in `data_q` and never exceeds DEPTH (64 by default). The register length and the tally width, ceil(log2(DEPTH+1)) bits, are parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Shift the register by one position this cycle |
| clear | input | 1 | Synchronous clear of register and tally; overrides shift_en |
| din | input | 1 | Serial bit that enters at bit 0 |
| data_q | output | DEPTH | Parallel register contents |
| ones_q | output | CNT_W | Number of ones currently held in data_q |

## Verification
A clear and a shift can be requested in the same cycle. The design must then act on the clear alone: both the register and the tally go to zero, and the tally does not take the step the shift would have produced. The bench provokes this by raising `clear` together with `shift_en` after the register has been filled with ones, and after mixed patterns, including cycles where a 1 enters while a 0 leaves. Each such cycle is judged against a queued expectation of an empty register and a zero tally. In the cycles that follow, the tally is compared with a count of the ones in the parallel output, and this comparison is made on every cycle.

// File: rtl/ost_pkg.sv
package ost_pkg;

  // Kind of change the tally takes on one clock.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Decide the tally step from the bit coming in and the bit falling off.
  function automatic step_e classify_step(input logic enter_bit,
                                          input logic leave_bit);
    step_e kind;
    if (enter_bit == leave_bit)
      kind = STEP_HOLD;
    else if (enter_bit)
      kind = STEP_UP;
    else
      kind = STEP_DOWN;
    return kind;
  endfunction

endpackage

// File: rtl/ost_shift_core.sv
module ost_shift_core #(
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic             enter_bit,
  output logic [DEPTH-1:0] stages_q,
  output logic             leave_bit
);

  logic [DEPTH-1:0] feed;

  // Each stage takes its lower neighbour; stage 0 takes the serial input.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign feed[i] = enter_bit;
    end else begin : g_body
      assign feed[i] = stages_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stages_q[i] <= 1'b0;
      else if (clear)
        stages_q[i] <= 1'b0;
      else if (advance)
        stages_q[i] <= feed[i];
    end
  end

  assign leave_bit = stages_q[DEPTH-1];

endmodule

// File: rtl/ost_step_dec.sv
module ost_step_dec
  import ost_pkg::*;
(
  input  logic  fire,
  input  logic  enter_bit,
  input  logic  leave_bit,
  output step_e step
);

  always_comb begin
    if (fire)
      step = classify_step(enter_bit, leave_bit);
    else
      step = STEP_HOLD;
  end

endmodule

// File: rtl/ost_tally_ctr.sv
module ost_tally_ctr
  import ost_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  step_e            step,
  output logic [CNT_W-1:0] count_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] apply_step(input logic [CNT_W-1:0] cur,
                                                  input step_e kind);
    logic [CNT_W-1:0] nxt;
    case (kind)
      STEP_UP:   nxt = cur + ONE;
      STEP_DOWN: nxt = cur - ONE;
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (clear)
      count_q <= '0;
    else
      count_q <= apply_step(count_q, step);
  end

endmodule

// File: rtl/ones_tally_shreg.sv
module ones_tally_shreg
  import ost_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             clear,
  input  logic             din,
  output logic [DEPTH-1:0] data_q,
  output logic [CNT_W-1:0] ones_q
);

  // Named internal events, visible to the bound checker.
  logic  shift_fire;
  logic  leave_bit;
  step_e step_kind;

  assign shift_fire = shift_en & ~clear;

  ost_shift_core #(.DEPTH(DEPTH)) core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .advance   (shift_fire),
    .enter_bit (din),
    .stages_q  (data_q),
    .leave_bit (leave_bit)
  );

  ost_step_dec dec_i (
    .fire      (shift_fire),
    .enter_bit (din),
    .leave_bit (leave_bit),
    .step      (step_kind)
  );

  ost_tally_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .step    (step_kind),
    .count_q (ones_q)
  );

endmodule

// File: rtl/ost_checker.sv
module ost_checker
  import ost_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_en,
  input logic             clear,
  input logic             din,
  input logic [DEPTH-1:0] data_q,
  input logic [CNT_W-1:0] ones_q,
  input logic             leave_bit,
  input step_e            step_kind
);

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clear) |=> (data_q == {$past(data_q[DEPTH-2:0]), $past(din)}));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clear) |=> ($stable(data_q) && $stable(ones_q)));

  assert_same_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clear && (din == data_q[DEPTH-1])) |=> $stable(ones_q));

  assert_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clear && din && !data_q[DEPTH-1])
      |=> (ones_q == $past(ones_q) + CNT_W'(1)));

  assert_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clear && !din && data_q[DEPTH-1])
      |=> (ones_q == $past(ones_q) - CNT_W'(1)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> ((data_q == '0) && (ones_q == '0)));

  assert_tally_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q == CNT_W'($countones(data_q)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ones_q) <= DEPTH);

  // The departing-bit tap and the step decoder agree (R5/R6 internal view).
  assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_kind == STEP_UP) |-> (din && !leave_bit && shift_en && !clear));

  assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_kind == STEP_DOWN) |-> (!din && leave_bit && shift_en && !clear));

endmodule

bind ones_tally_shreg ost_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .shift_en  (shift_en),
  .clear     (clear),
  .din       (din),
  .data_q    (data_q),
  .ones_q    (ones_q),
  .leave_bit (leave_bit),
  .step_kind (step_kind)
);

// File: tb/ones_tally_shreg_tb_top.sv
module ones_tally_shreg_tb_top;

  localparam int DEPTH = 64;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int WATCHDOG_CYCLES = 20000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             shift_en = 1'b0;
  logic             clear = 1'b0;
  logic             din = 1'b0;
  logic [DEPTH-1:0] data_q;
  logic [CW-1:0]    ones_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Scoreboard queues, filled by the driver, drained by the monitor.
  logic [DEPTH-1:0] exp_data_q[$];
  int               exp_cnt_q[$];
  string            data_tag_q[$];
  string            cnt_tag_q[$];

  // Bench-side reference state.
  logic [DEPTH-1:0] model_reg = '0;
  logic [15:0]      lfsr = 16'hACE1;

  always #4 clk = ~clk;   // 125 MHz

  ones_tally_shreg #(.DEPTH(DEPTH)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .clear    (clear),
    .din      (din),
    .data_q   (data_q),
    .ones_q   (ones_q)
  );

  task automatic check_eq(input string req, input logic [63:0] act,
                          input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic drive(input bit sh, input bit clr, input bit d);
    string dtag;
    string ctag;
    @(negedge clk);
    shift_en = sh;
    clear    = clr;
    din      = d;
    if (clr) begin
      dtag = "R7"; ctag = "R7";
      model_reg = '0;
    end else if (!sh) begin
      dtag = "R3"; ctag = "R3";
    end else begin
      dtag = "R2";
      if (d == model_reg[DEPTH-1]) ctag = "R4";
      else if (d)                  ctag = "R5";
      else                         ctag = "R6";
      model_reg = {model_reg[DEPTH-2:0], d};
    end
    exp_data_q.push_back(model_reg);
    exp_cnt_q.push_back($countones(model_reg));
    data_tag_q.push_back(dtag);
    cnt_tag_q.push_back(ctag);
  endtask

  // Monitor: 2 ns after each rising edge, compare with the oldest item.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (exp_data_q.size() > 0) begin
        logic [DEPTH-1:0] ed;
        int               ec;
        string            dt;
        string            ct;
        ed = exp_data_q.pop_front();
        ec = exp_cnt_q.pop_front();
        dt = data_tag_q.pop_front();
        ct = cnt_tag_q.pop_front();
        check_eq(dt, 64'(data_q), 64'(ed));
        check_eq(ct, 64'(ones_q), 64'(ec));
      end
      // R8: tally agrees with the ones visible at the parallel output.
      check_eq("R8", 64'(ones_q), 64'($countones(data_q)));
    end
  end

  function automatic bit next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    #1;
    check_eq("R1", 64'(data_q), 64'd0);
    check_eq("R1", 64'(ones_q), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Fill with ones: R5 on every step, tally reaches DEPTH (R8 boundary).
    for (int i = 0; i < DEPTH; i++) drive(1'b1, 1'b0, 1'b1);
    // Full register, ones keep entering: R4 at the top.
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b1);
    // Hold with din toggling (R3).
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b0, i[0]);
    // Zeros enter while ones leave: R6.
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, 1'b0);
    // Clear together with shift (R7 priority).
    drive(1'b1, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b1);
    // Alternating pattern over more than the full length.
    for (int i = 0; i < DEPTH + 20; i++) drive(1'b1, 1'b0, i[0]);
    // Clear with shift disabled.
    drive(1'b0, 1'b1, 1'b0);
    // Pseudo-random mix of shifts, holds and rare clears.
    for (int i = 0; i < 400; i++) begin
      bit s;
      bit c;
      s = next_rand() | next_rand();
      c = (i % 97) == 50;
      drive(s, c, next_rand());
    end
    // Drain with zeros down to an empty tally.
    for (int i = 0; i < DEPTH; i++) drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #3;
    if (!done) begin
      check_eq("R8", 64'(ones_q), 64'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule